// File: doc/BRIEF.md
# Address-Threshold Write Protect Unit

This unit guards a small word-addressed non-volatile array against unwanted writes. It holds one threshold address. Every word at or above that address is read-only. A valid flag, kept apart from the threshold, marks the "nothing protected" state. Address zero therefore remains usable as a threshold that protects the whole array.

The serial command slave decodes each framed instruction. It presents the result on a one-cycle strobe: a 2-bit opcode, the 6-bit address field, and the level of the dedicated protect-enable pin during that frame. When the pin is low, the frame is an ordinary array instruction. When the pin is high, the frame targets the protect register. The supported register commands are enable, read, write, clear and permanent lock.

Changing the register takes three conditions: an enable command on the strobe just before, the memory write-enable state active, and the one-way lock not yet set. Each accepted change raises a pulse that starts the shared self-timed programming period. The array write path asks for permission with a word address and gets back a combinational permit flag.

Top module: `wp_unit`

## Requirements
- R1: After reset the threshold is marked invalid, the lock is clear and no enable is pending. Every word address is permitted, and a register read returns 6'b111111.
- R2: `wr_permit_o` is 0 exactly when the threshold is valid and `wr_addr_i` is greater than or equal to the stored threshold. Otherwise it is 1.
- R3: A register write (protect-enable high, opcode 2'b01) stores the low 4 bits of `field_i` as the threshold and marks it valid. The upper 2 field bits have no effect.
- R4: A register write, clear (opcode 2'b11) or lock (opcode 2'b00 with field 6'b000000) changes nothing unless the strobe immediately before it was a register enable (opcode 2'b00 with field bits [5:4] = 2'b11).
- R5: A pending enable is used up by the next strobe of any kind, whether or not that strobe is accepted.
- R6: A register write, clear or lock changes nothing while `wr_en_i` is low.
- R7: An accepted clear marks the threshold invalid, which permits every address. A stored threshold of 0 refuses every address.
- R8: Once a lock is accepted, no later write or clear changes the register, and the lock never releases before reset.
- R9: A register read (protect-enable high, opcode 2'b10) needs no enable. It pulses `rd_valid_o` in the cycle after the strobe, with `rd_data_o` = {2'b00, threshold} when valid and 6'b111111 when invalid.
- R10: `prog_start_o` pulses for one cycle after each accepted write, clear or lock, and at no other time.
- R11: A strobe with protect-enable low never changes the threshold, the valid flag or the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_stb_i | input | 1 | One-cycle strobe marking a decoded instruction |
| prot_en_i | input | 1 | Protect-enable pin level during the instruction |
| op_i | input | 2 | Decoded instruction opcode |
| field_i | input | 6 | Instruction address field |
| wr_en_i | input | 1 | Memory write-enable state is active |
| wr_addr_i | input | 4 | Word address of a pending array write |
| wr_permit_o | output | 1 | Array write to `wr_addr_i` is allowed |
| prog_start_o | output | 1 | Start pulse for the self-timed programming period |
| rd_valid_o | output | 1 | Register read data is valid |
| rd_data_o | output | 6 | Register value for shift-out |

## Verification
Several properties are checked on every cycle:
- the lock stays set once set;
- a locked register holds its value;
- array instructions leave the register untouched;
- a pending enable never survives a foreign strobe;
- a change of the register always follows a pending enable while write-enable is active;
- programming start pulses never come back to back.

Some behaviours can only be shown by the bench's command sequences. These include the exact threshold comparison at its boundary, the masking of the upper field bits, the read-back encoding of the cleared state, and the sequence in which an enable is spent by an intervening array instruction or refused for lack of write-enable.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ARRAY,
    CMD_PEN,
    CMD_PRD,
    CMD_PWR,
    CMD_PCLR,
    CMD_PDIS,
    CMD_PBAD
  } wp_cmd_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_CLEAR   = 2'b11;
endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_pkg::*;
#(
  parameter int unsigned FIELD_W = 6
) (
  input  logic               stb_i,
  input  logic               prot_en_i,
  input  logic [1:0]         op_i,
  input  logic [FIELD_W-1:0] field_i,
  output wp_cmd_e            cmd_o
);
  logic pen_pat, dis_pat;
  assign pen_pat = (field_i[FIELD_W-1 -: 2] == 2'b11);
  assign dis_pat = (field_i == '0);

  always_comb begin
    cmd_o = CMD_NONE;
    if (stb_i) begin
      if (!prot_en_i) begin
        cmd_o = CMD_ARRAY;
      end else begin
        unique case (op_i)
          OP_READ:  cmd_o = CMD_PRD;
          OP_WRITE: cmd_o = CMD_PWR;
          OP_CLEAR: cmd_o = CMD_PCLR;
          default: begin
            if (pen_pat)      cmd_o = CMD_PEN;
            else if (dis_pat) cmd_o = CMD_PDIS;
            else              cmd_o = CMD_PBAD;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned FIELD_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  wp_cmd_e            cmd_i,
  input  logic [ADDR_W-1:0]  new_thr_i,
  input  logic               wr_en_i,
  output logic [ADDR_W-1:0]  thr_o,
  output logic               valid_o,
  output logic               prog_start_o,
  output logic               rd_valid_o,
  output logic [FIELD_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = FIELD_W - ADDR_W;

  logic [ADDR_W-1:0]  thr_q;
  logic               valid_q, locked_q, armed_q, start_q, rdv_q;
  logic [FIELD_W-1:0] rd_q;
  logic               modify, accept;

  assign modify = (cmd_i == CMD_PWR) || (cmd_i == CMD_PCLR) || (cmd_i == CMD_PDIS);
  assign accept = modify && armed_q && wr_en_i && !locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q    <= '0;
      valid_q  <= 1'b0;
      locked_q <= 1'b0;
      armed_q  <= 1'b0;
      start_q  <= 1'b0;
      rdv_q    <= 1'b0;
      rd_q     <= '1;
    end else begin
      start_q <= accept;
      rdv_q   <= (cmd_i == CMD_PRD);
      if (cmd_i == CMD_PRD) rd_q <= valid_q ? {{PAD_W{1'b0}}, thr_q} : '1;
      if (cmd_i != CMD_NONE) armed_q <= (cmd_i == CMD_PEN);
      if (accept) begin
        unique case (cmd_i)
          CMD_PWR: begin
            thr_q   <= new_thr_i;
            valid_q <= 1'b1;
          end
          CMD_PCLR: valid_q  <= 1'b0;
          default:  locked_q <= 1'b1;
        endcase
      end
    end
  end

  assign thr_o        = thr_q;
  assign valid_o      = valid_q;
  assign prog_start_o = start_q;
  assign rd_valid_o   = rdv_q;
  assign rd_data_o    = rd_q;

  a_r8_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
  a_r8_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> ($stable(thr_q) && $stable(valid_q)));
  a_r11_array_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ARRAY) |=> ($stable(thr_q) && $stable(valid_q) && $stable(locked_q)));
  a_r5_arm_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cmd_i != CMD_NONE && cmd_i != CMD_PEN) |=> !armed_q);
  a_r4_change_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q != $past(valid_q) || thr_q != $past(thr_q)) |-> $past(armed_q && wr_en_i));
  a_r10_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
endmodule

// File: rtl/wp_compare.sv
module wp_compare #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] thr_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              permit_o
);
  assign permit_o = !(valid_i && (addr_i >= thr_i));
endmodule

// File: rtl/wp_unit.sv
module wp_unit
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned FIELD_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_stb_i,
  input  logic               prot_en_i,
  input  logic [1:0]         op_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  output logic               wr_permit_o,
  output logic               prog_start_o,
  output logic               rd_valid_o,
  output logic [FIELD_W-1:0] rd_data_o
);
  wp_cmd_e           cmd;
  logic [ADDR_W-1:0] thr;
  logic              thr_valid;

  wp_cmd_decode #(.FIELD_W(FIELD_W)) i_decode (
    .stb_i    (cmd_stb_i),
    .prot_en_i(prot_en_i),
    .op_i     (op_i),
    .field_i  (field_i),
    .cmd_o    (cmd)
  );

  wp_prot_state #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .new_thr_i   (field_i[ADDR_W-1:0]),
    .wr_en_i     (wr_en_i),
    .thr_o       (thr),
    .valid_o     (thr_valid),
    .prog_start_o(prog_start_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  wp_compare #(.ADDR_W(ADDR_W)) i_compare (
    .thr_i   (thr),
    .valid_i (thr_valid),
    .addr_i  (wr_addr_i),
    .permit_o(wr_permit_o)
  );

  a_r7_invalid_permits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_valid |-> wr_permit_o);
endmodule

// File: tb/test_wp_unit.sv
module test_wp_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, pe = 1'b0, we = 1'b0;
  logic [1:0] op = 2'b00;
  logic [5:0] fld = '0;
  logic [3:0] waddr = '0;
  logic       permit, pstart, rdv;
  logic [5:0] rdata;

  int checks = 0, errors = 0;
  logic [5:0] exp_q[$];
  string      req_q[$];

  // bench model
  logic [3:0] m_thr = '0;
  logic       m_valid = 1'b0, m_lock = 1'b0, m_arm = 1'b0;

  always #4ns clk = ~clk;

  wp_unit i_wp_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmd_stb_i(stb), .prot_en_i(pe), .op_i(op),
    .field_i(fld), .wr_en_i(we), .wr_addr_i(waddr), .wr_permit_o(permit),
    .prog_start_o(pstart), .rd_valid_o(rdv), .rd_data_o(rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rdv) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected read", int'(rdata), 0);
      end else begin
        logic [5:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(rdata == e, r, int'(rdata), int'(e));
      end
    end
  end

  task automatic issue(input bit p, input logic [1:0] o, input logic [5:0] f, input bit w,
                       input string req);
    bit exp_start = 1'b0;
    @(negedge clk);
    pe = p; op = o; fld = f; we = w; stb = 1'b1;
    if (p && o == 2'b10) begin
      exp_q.push_back(m_valid ? {2'b00, m_thr} : 6'h3f);
      req_q.push_back(req);
    end
    if (p && o == 2'b00 && f[5:4] == 2'b11) begin
      m_arm = 1'b1;
    end else begin
      if (p && m_arm && w && !m_lock) begin
        if (o == 2'b01) begin m_thr = f[3:0]; m_valid = 1'b1; exp_start = 1'b1; end
        else if (o == 2'b11) begin m_valid = 1'b0; exp_start = 1'b1; end
        else if (o == 2'b00 && f == 6'd0) begin m_lock = 1'b1; exp_start = 1'b1; end
      end
      m_arm = 1'b0;
    end
    @(negedge clk);
    stb = 1'b0;
    check(pstart == exp_start, {req, " prog_start"}, int'(pstart), int'(exp_start));
  endtask

  task automatic chk_permit(input logic [3:0] a, input string req);
    bit e;
    waddr = a;
    #1ns;
    e = !(m_valid && a >= m_thr);
    check(permit == e, req, int'(permit), int'(e));
  endtask

  task automatic rd(input string req);
    issue(1'b1, 2'b10, 6'h00, 1'b1, req);
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(pstart == 1'b0 && rdv == 1'b0, "R1 idle outputs", int'({pstart, rdv}), 0);
    for (int a = 0; a < 16; a += 5) chk_permit(4'(a), "R1 permit after reset");
    rd("R1 R9 read after reset");
    // R4 write without enable
    issue(1'b1, 2'b01, 6'h05, 1'b1, "R4 write without enable");
    rd("R4 unchanged");
    // R3 write with upper bits set
    issue(1'b1, 2'b00, 6'h30, 1'b1, "R4 enable");
    issue(1'b1, 2'b01, 6'h35, 1'b1, "R3 R10 write");
    chk_permit(4'd4, "R2 below threshold");
    chk_permit(4'd5, "R2 at threshold");
    chk_permit(4'd15, "R2 above threshold");
    rd("R3 R9 read threshold");
    // R5 enable spent by array command; R11 array write leaves register
    issue(1'b1, 2'b00, 6'h3a, 1'b1, "R5 enable");
    issue(1'b0, 2'b01, 6'h00, 1'b1, "R11 array write");
    issue(1'b1, 2'b11, 6'h00, 1'b1, "R5 clear after spent enable");
    rd("R5 R11 still set");
    // R5 enable spent by register read
    issue(1'b1, 2'b00, 6'h30, 1'b1, "R5 enable");
    rd("R5 read spends enable");
    issue(1'b1, 2'b11, 6'h00, 1'b1, "R5 clear after read");
    rd("R5 still set after read");
    // R6 write-enable low
    issue(1'b1, 2'b00, 6'h30, 1'b0, "R6 enable");
    issue(1'b1, 2'b11, 6'h00, 1'b0, "R6 clear without write-enable");
    rd("R6 unchanged");
    // R7 clear
    issue(1'b1, 2'b00, 6'h30, 1'b1, "R7 enable");
    issue(1'b1, 2'b11, 6'h00, 1'b1, "R7 clear");
    chk_permit(4'd15, "R7 cleared permits");
    rd("R7 R9 cleared read");
    issue(1'b1, 2'b00, 6'h30, 1'b1, "R7 enable");
    issue(1'b1, 2'b01, 6'h00, 1'b1, "R7 threshold zero");
    chk_permit(4'd0, "R7 zero protects all");
    chk_permit(4'd9, "R7 zero protects all");
    // R8 lock
    issue(1'b1, 2'b00, 6'h30, 1'b1, "R8 enable");
    issue(1'b1, 2'b00, 6'h00, 1'b1, "R8 lock");
    issue(1'b1, 2'b00, 6'h30, 1'b1, "R8 enable");
    issue(1'b1, 2'b11, 6'h00, 1'b1, "R8 clear after lock");
    issue(1'b1, 2'b00, 6'h30, 1'b1, "R8 enable");
    issue(1'b1, 2'b01, 6'h09, 1'b1, "R8 write after lock");
    chk_permit(4'd3, "R8 still protected");
    rd("R8 frozen value");
    issue(1'b1, 2'b00, 6'h30, 1'b1, "R8 enable");
    issue(1'b1, 2'b00, 6'h00, 1'b1, "R10 relock no pulse");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 reads outstanding", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule